// File: doc/BRIEF.md
# Serial-Loaded Cartridge Bank Mapper

This block sits on a cartridge and turns the CPU's 32 KB window address into a 21-bit address for a 2 MB flash device. The host CPU drives three general-purpose output lines: a shift clock, a serial data bit and a latch strobe. Each rising edge of the shift clock pushes the data bit into an 8-bit shift register. A rising edge of the latch strobe moves the low seven bits of that register into the active bank register. The shift register can therefore be refilled without disturbing the bank that is currently mapped.

The window is split on its top address bit. The lower 16 KB half is switchable and uses the active bank as the upper seven flash address bits. The upper 16 KB half always reads the last bank (127), so the CPU's reset and interrupt vectors are valid whatever the bank register holds. The three host lines are registered in the system clock domain. Edges are found by comparing each registered line with its value one cycle earlier.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the active bank is 0, so a lower-half window address maps to flash address bits [20:14] = 0.
- R2: Host line bit 0 is the shift clock, bit 1 is serial data and bit 2 is the latch strobe.
- R3: Each 0-to-1 transition of the shift clock shifts the register one place toward its MSB and places the data bit in bit 0. After eight clocks the last bit sent sits in bit 0.
- R4: The shift register does not change while the shift clock stays high, on a 1-to-0 transition, or when the data line toggles with the clock steady.
- R5: A 0-to-1 transition of the latch copies shift register bits [6:0] into the active bank. Bit 7 is discarded.
- R6: Shifting without a latch edge leaves the active bank and the address mapping unchanged.
- R7: When window address bit 14 is 0, the flash address is {active bank, window address bits [13:0]}.
- R8: When window address bit 14 is 1, the flash address is {7'd127, window address bits [13:0]}, whatever the bank register holds.
- R9: A change on a host line takes effect at the second rising system clock edge after it is presented. The first edge registers the line and the second edge acts on it.
- R10: If the shift clock and the latch rise in the same cycle, the bank takes the shift register contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_lines_i | input | 3 | Host GPIO lines: bit 0 shift clock, bit 1 data, bit 2 latch |
| win_addr_i | input | 15 | CPU address inside the 32 KB cartridge window |
| flash_addr_o | output | 21 | Address driven to the flash device |

## Verification
The bench sends bytes whose bit 7 is set, to show that the top bit never reaches the bank. A mapper that kept all eight bits would mis-address the lower window. It shifts without latching and holds the clock high while toggling data. A design that detected levels instead of edges, or that fed the shift register straight to the address, would show the wrong bank. It raises clock and latch together, where a design that latched after the shift would take the new value. It also samples the bank after one and after two clock edges to pin the latency. Throughout, it toggles the window's top bit, where any leak of the bank register into the fixed half would break the mapping to bank 127.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    localparam int HOST_W    = 3;
    localparam int SCLK_LINE = 0;
    localparam int SDAT_LINE = 1;
    localparam int LTCH_LINE = 2;
endpackage

// File: rtl/cbm_serial_bank.sv
module cbm_serial_bank #(
    parameter int SR_W   = 8,
    parameter int BANK_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [cbm_pkg::HOST_W-1:0] host_i,
    output logic [BANK_W-1:0]         bank_o
);
    import cbm_pkg::*;

    typedef struct packed {
        logic [HOST_W-1:0] line;
        logic              sclk_prev;
        logic              ltch_prev;
        logic [SR_W-1:0]   sr;
        logic [BANK_W-1:0] bank;
    } st_t;

    st_t  st_d, st_q;
    logic sclk_rise, ltch_rise;

    always_comb begin
        st_d      = st_q;
        sclk_rise = st_q.line[SCLK_LINE] & ~st_q.sclk_prev;
        ltch_rise = st_q.line[LTCH_LINE] & ~st_q.ltch_prev;
        st_d.line      = host_i;
        st_d.sclk_prev = st_q.line[SCLK_LINE];
        st_d.ltch_prev = st_q.line[LTCH_LINE];
        if (sclk_rise) begin
            st_d.sr = {st_q.sr[SR_W-2:0], st_q.line[SDAT_LINE]};
        end
        if (ltch_rise) begin
            st_d.bank = st_q.sr[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.bank;

    p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> st_q.sr == {$past(st_q.sr[SR_W-2:0]), $past(st_q.line[SDAT_LINE])});

    p_shift_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(st_q.sr));

    p_latch_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ltch_rise |=> bank_o == $past(st_q.sr[BANK_W-1:0]));

    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ltch_rise |=> $stable(bank_o));
endmodule

// File: rtl/cbm_addr_map.sv
module cbm_addr_map #(
    parameter int BANK_W = 7,
    parameter int OFFS_W = 14
) (
    input  logic [BANK_W-1:0]        bank_i,
    input  logic [OFFS_W:0]          win_addr_i,
    output logic [BANK_W+OFFS_W-1:0] flash_addr_o
);
    localparam logic [BANK_W-1:0] FIXED_BANK = '1;

    logic [BANK_W-1:0] sel_bank;

    always_comb begin
        sel_bank     = win_addr_i[OFFS_W] ? FIXED_BANK : bank_i;
        flash_addr_o = {sel_bank, win_addr_i[OFFS_W-1:0]};
    end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
    parameter int SR_W   = 8,
    parameter int BANK_W = 7,
    parameter int OFFS_W = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [cbm_pkg::HOST_W-1:0] host_lines_i,
    input  logic [OFFS_W:0]            win_addr_i,
    output logic [BANK_W+OFFS_W-1:0]   flash_addr_o
);
    localparam int FLASH_W = BANK_W + OFFS_W;

    logic [BANK_W-1:0] bank;

    cbm_serial_bank #(.SR_W(SR_W), .BANK_W(BANK_W)) u_serial (
        .clk    (clk),
        .rst_n  (rst_n),
        .host_i (host_lines_i),
        .bank_o (bank)
    );

    cbm_addr_map #(.BANK_W(BANK_W), .OFFS_W(OFFS_W)) u_map (
        .bank_i       (bank),
        .win_addr_i   (win_addr_i),
        .flash_addr_o (flash_addr_o)
    );

    p_fixed_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_addr_i[OFFS_W] |-> flash_addr_o[FLASH_W-1:OFFS_W] == {BANK_W{1'b1}});

    p_offset_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flash_addr_o[OFFS_W-1:0] == win_addr_i[OFFS_W-1:0]);
endmodule

// File: tb/cart_bank_mapper_tb.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host = 3'b000;
    logic [14:0] waddr = 15'h0000;
    logic [20:0] faddr;

    int vec = 0;
    int bad = 0;

    int m_cur = 0, m_prev = 0, m_sr = 0, m_bank = 0;

    always #2.5 clk = ~clk;

    cart_bank_mapper u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_lines_i (host),
        .win_addr_i   (waddr),
        .flash_addr_o (faddr)
    );

    function automatic int exp_flash(int bank, logic [14:0] a);
        int b;
        b = a[14] ? 127 : bank;
        return (b << 14) | int'(a[13:0]);
    endfunction

    task automatic compare(input int exp, input string tag);
        vec++;
        if (int'(faddr) != exp) begin
            bad++;
            $display("FAIL %s: flash_addr actual=%06h expected=%06h", tag, faddr, exp);
        end
    endtask

    // one system clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic [2:0] g, input logic [14:0] a, input string tag);
        host  = g;
        waddr = a;
        @(posedge clk);
        if (rst_n) begin
            if ((m_cur & 4) != 0 && (m_prev & 4) == 0) m_bank = m_sr & 127;
            if ((m_cur & 1) != 0 && (m_prev & 1) == 0) m_sr = ((m_sr << 1) | ((m_cur >> 1) & 1)) & 255;
            m_prev = m_cur;
            m_cur  = int'(g);
        end
        @(negedge clk);
        compare(exp_flash(m_bank, a), tag);
    endtask

    task automatic chk_bank(input int bank, input logic [14:0] a, input string tag);
        waddr = a;
        #0.1;
        compare(exp_flash(bank, a), tag);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            cyc({1'b0, b[i], 1'b0}, 15'h0100, "R2 serial send");
            cyc({1'b0, b[i], 1'b1}, 15'h4100, "R3 clock edge");
            cyc({1'b0, b[i], 1'b0}, 15'h0101, "R3 clock low");
        end
    endtask

    task automatic do_latch();
        cyc(3'b100, 15'h2000, "R5 latch high");
        cyc(3'b000, 15'h2001, "R5 latch low");
        cyc(3'b000, 15'h2002, "R5 settle");
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset bank is zero
        cyc(3'b000, 15'h1abc, "R1 reset");
        chk_bank(0, 15'h3fff, "R1 reset bank zero");
        chk_bank(127, 15'h4000, "R8 fixed bank after reset");

        // R5: bit 7 dropped
        send_byte(8'hA5);
        do_latch();
        chk_bank(8'h25, 15'h1234, "R5 low seven bits");

        // R6: shift without latch
        send_byte(8'h0F);
        chk_bank(8'h25, 15'h0777, "R6 no latch no change");

        // R4: data toggles with clock steady low, then high
        for (int i = 0; i < 6; i++) cyc({1'b0, i[0], 1'b0}, 15'h0010, "R4 data toggle clock low");
        do_latch();
        chk_bank(8'h0F, 15'h0020, "R4 no extra shift");
        send_byte(8'h81);
        cyc(3'b001, 15'h0030, "R4 clock rise");
        for (int i = 0; i < 6; i++) cyc({1'b0, i[0], 1'b1}, 15'h0031, "R4 clock held high");
        cyc(3'b000, 15'h0032, "R4 clock fall");
        do_latch();
        chk_bank(8'h02, 15'h0033, "R3 eight clocks last bit in bit0");

        // R10: simultaneous clock and latch
        send_byte(8'h33);
        cyc(3'b111, 15'h0040, "R10 joint rise");
        cyc(3'b000, 15'h0041, "R10 lines low");
        cyc(3'b000, 15'h0042, "R10 settle");
        chk_bank(8'h33, 15'h0043, "R10 bank takes pre-shift value");
        do_latch();
        chk_bank(8'h67, 15'h0044, "R10 shifted value latched later");

        // R9: latency of two edges
        send_byte(8'h11);
        cyc(3'b100, 15'h0050, "R9 latch presented");
        chk_bank(8'h67, 15'h0051, "R9 one edge no change");
        cyc(3'b100, 15'h0052, "R9 second edge");
        chk_bank(8'h11, 15'h0053, "R9 two edges applied");
        cyc(3'b000, 15'h0054, "R9 release");

        // R8: upper half fixed for any bank
        for (int i = 0; i < 16; i++) begin
            logic [14:0] a;
            a = 15'h4000 | 15'(i * 997);
            cyc(3'b000, a, "R8 upper half bank 127");
        end

        // mixed sweep against the model
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[2:0], {lf[15:9], lf[7:0]}, "R7 mixed sweep");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule